// File: doc/BRIEF.md
# Fractional-Increment PTP Hardware Clock

This block keeps a free-running 64-bit nanosecond time value. Below the nanosecond count sits a 32-bit fractional accumulator. The clock advances on periodic ticks of the local reference clock. Each tick adds a programmable fixed-point increment, so software sets the clock rate in steps much finer than one part per billion. A word-addressed register file controls the clock. Through it software loads an absolute time, moves the clock forward or backward by a small signed amount, and stages a new increment that takes effect only when a command bit is written.

The counter is read through two 32-bit words. The readback has no hardware snapshot. Software reads the upper word, then the lower word, then the upper word again, and retries until the two upper reads agree. The current time and fraction are also driven on output ports. A one-cycle pulse on `tick_pulse` marks every tick.

Top module: `ptp_frac_clock`

## Requirements
- R1: After reset the time and fraction are zero and the control word reads zero. The staged increment reads 1 in word 6 and 0xAAAAAAAA in word 7. The active increment equals that nominal value, 0x1_AAAA_AAAA in Q16.32 nanoseconds (about 1.6667 ns for a 600 MHz reference).
- R2: Register words: 0 control, 1 command, 2 load-high, 3 load-low, 4 nudge-ns, 5 nudge-fraction, 6 increment-ns (bits 15:0 only), 7 increment-fraction, 8 time-high, 9 time-low. In the control word, bit 0 is run enable, bit 4 is the monotonic flag, bit 8 is the time-output flag, bits 16:12 are the MAC output interval and bits 23:20 are the tick interval N. Unused control bits read zero. The command word and unmapped offsets read zero.
- R3: The clock advances only while run enable is 1. A tick occurs once every N+1 clocks.
- R4: The 96-bit time (64 ns bits and 32 fraction bits) gains the active increment times N+1 at every tick. Over any whole number of tick periods, the average gain is exactly one increment per clock.
- R5: Command bit 0 loads the time from {load-high, load-low} and clears the fraction. This load overrides any tick or nudge in the same clock.
- R6: Command bit 16 adds the Q32.32 nudge {nudge-ns, nudge-fraction}, and command bit 8 subtracts it. If both bits are set in one write, the time does not change. A nudge combines with a tick in the same clock.
- R7: Command bit 24 makes the staged increment active one clock after the command write. Writing words 6 and 7 without that command does not change the rate.
- R8: A staged increment of zero is refused when applied, and the previous active increment remains. The active increment is never zero.
- R9: Word 8 reads the current time bits 63:32 and word 9 reads bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| time_ns | output | 64 | Whole nanoseconds of the current time |
| time_frac | output | 32 | Fractional nanoseconds of the current time |
| tick_pulse | output | 1 | One-cycle marker of each tick |

## Verification
The load assertion assumes that the load registers are not rewritten in the same clock as the load command. The bench always writes them one word per clock before it issues the command. The increment assertion assumes that the staged words hold still for the clock after an apply command. The bench leaves at least one idle clock after every apply. The quiet-hold property assumes that nothing except ticks, loads and nudges changes the time. Rate measurements therefore span whole tick periods with the register bus idle.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;
  localparam int WORD_W   = 32;
  localparam int FRAC_W   = 32;
  localparam int TIME_W   = 64;
  localparam int ACC_W    = TIME_W + FRAC_W;
  localparam int INC_NS_W = 16;
  localparam int INC_W    = INC_NS_W + FRAC_W;
  localparam int NUDGE_W  = WORD_W + FRAC_W;
  localparam int TIVL_W   = 4;
  localparam int MIVL_W   = 5;
  localparam int ADDR_W   = 4;

  // word offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_CMD      = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_LOAD_HI  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_LOAD_LO  = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_NUDGE_NS = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_NUDGE_FR = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_INC_NS   = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_INC_FR   = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_TIME_HI  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_TIME_LO  = 4'd9;

  // command bits
  localparam int CMD_LOAD_BIT  = 0;
  localparam int CMD_SUB_BIT   = 8;
  localparam int CMD_ADD_BIT   = 16;
  localparam int CMD_APPLY_BIT = 24;

  // control bits
  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_MONO_BIT = 4;
  localparam int CTL_TOUT_BIT = 8;
  localparam int CTL_MIVL_LSB = 12;
  localparam int CTL_TIVL_LSB = 20;

  typedef struct packed {
    logic [TIVL_W-1:0] tick_ival;
    logic [MIVL_W-1:0] mac_ival;
    logic              tout_en;
    logic              mono_en;
    logic              run_en;
  } ctrl_t;

  // amount added by one tick that spans ival+1 clocks
  function automatic logic [ACC_W-1:0] tick_step(input logic [INC_W-1:0] inc,
                                                 input logic [TIVL_W-1:0] ival);
    return ACC_W'(inc) * (ACC_W'(ival) + ACC_W'(1));
  endfunction

  // signed nudge term in two's complement, zero when both or neither bit set
  function automatic logic [ACC_W-1:0] nudge_term(input logic [NUDGE_W-1:0] amt,
                                                  input logic add, input logic sub);
    logic [ACC_W-1:0] ext;
    ext = ACC_W'(amt);
    if (add && !sub)      return ext;
    else if (sub && !add) return ~ext + ACC_W'(1);
    else                  return '0;
  endfunction
endpackage

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen
  import ptp_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [TIVL_W-1:0] ival,
  output logic              tick
);
  logic [TIVL_W-1:0] cnt_q;

  assign tick = run_en && (cnt_q >= ival);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run_en) cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + TIVL_W'(1);
  end

  assert_idle_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tick);

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || ival == '0));
endmodule

// File: rtl/ptp_reg_file.sv
module ptp_reg_file
  import ptp_clk_pkg::*;
#(
  parameter int unsigned REF_HZ = 600_000_000
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [TIME_W-1:0]  cur_time,
  output ctrl_t              ctrl,
  output logic [TIME_W-1:0]  load_val,
  output logic [NUDGE_W-1:0] nudge_amt,
  output logic [INC_W-1:0]   active_inc,
  output logic               load_cmd,
  output logic               add_cmd,
  output logic               sub_cmd
);
  localparam logic [63:0]      NOM64   = (64'd1000000000 << 32) / 64'(REF_HZ);
  localparam logic [INC_W-1:0] NOM_INC = NOM64[INC_W-1:0];

  ctrl_t               ctrl_q;
  logic [WORD_W-1:0]   load_hi_q, load_lo_q, nudge_ns_q, nudge_fr_q, inc_fr_q;
  logic [INC_NS_W-1:0] inc_ns_q;
  logic [INC_W-1:0]    active_q;
  logic                apply_pend_q;
  logic                cmd_wr;
  logic [INC_W-1:0]    staged_inc;

  assign cmd_wr     = reg_wr && (reg_addr == OFS_CMD);
  assign load_cmd   = cmd_wr && reg_wdata[CMD_LOAD_BIT];
  assign add_cmd    = cmd_wr && reg_wdata[CMD_ADD_BIT];
  assign sub_cmd    = cmd_wr && reg_wdata[CMD_SUB_BIT];
  assign staged_inc = {inc_ns_q, inc_fr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      load_hi_q  <= '0;
      load_lo_q  <= '0;
      nudge_ns_q <= '0;
      nudge_fr_q <= '0;
      inc_ns_q   <= NOM_INC[INC_W-1:FRAC_W];
      inc_fr_q   <= NOM_INC[FRAC_W-1:0];
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL: begin
          ctrl_q.run_en    <= reg_wdata[CTL_RUN_BIT];
          ctrl_q.mono_en   <= reg_wdata[CTL_MONO_BIT];
          ctrl_q.tout_en   <= reg_wdata[CTL_TOUT_BIT];
          ctrl_q.mac_ival  <= reg_wdata[CTL_MIVL_LSB +: MIVL_W];
          ctrl_q.tick_ival <= reg_wdata[CTL_TIVL_LSB +: TIVL_W];
        end
        OFS_LOAD_HI:  load_hi_q  <= reg_wdata;
        OFS_LOAD_LO:  load_lo_q  <= reg_wdata;
        OFS_NUDGE_NS: nudge_ns_q <= reg_wdata;
        OFS_NUDGE_FR: nudge_fr_q <= reg_wdata;
        OFS_INC_NS:   inc_ns_q   <= reg_wdata[INC_NS_W-1:0];
        OFS_INC_FR:   inc_fr_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  // apply: capture staged words one clock after the command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apply_pend_q <= 1'b0;
      active_q     <= NOM_INC;
    end else begin
      apply_pend_q <= cmd_wr && reg_wdata[CMD_APPLY_BIT];
      if (apply_pend_q && staged_inc != '0) active_q <= staged_inc;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTL_RUN_BIT]                 = ctrl_q.run_en;
        reg_rdata[CTL_MONO_BIT]                = ctrl_q.mono_en;
        reg_rdata[CTL_TOUT_BIT]                = ctrl_q.tout_en;
        reg_rdata[CTL_MIVL_LSB +: MIVL_W]      = ctrl_q.mac_ival;
        reg_rdata[CTL_TIVL_LSB +: TIVL_W]      = ctrl_q.tick_ival;
      end
      OFS_LOAD_HI:  reg_rdata = load_hi_q;
      OFS_LOAD_LO:  reg_rdata = load_lo_q;
      OFS_NUDGE_NS: reg_rdata = nudge_ns_q;
      OFS_NUDGE_FR: reg_rdata = nudge_fr_q;
      OFS_INC_NS:   reg_rdata = WORD_W'(inc_ns_q);
      OFS_INC_FR:   reg_rdata = inc_fr_q;
      OFS_TIME_HI:  reg_rdata = cur_time[TIME_W-1:WORD_W];
      OFS_TIME_LO:  reg_rdata = cur_time[WORD_W-1:0];
      default:      reg_rdata = '0;
    endcase
  end

  assign ctrl       = ctrl_q;
  assign load_val   = {load_hi_q, load_lo_q};
  assign nudge_amt  = {nudge_ns_q, nudge_fr_q};
  assign active_inc = active_q;

  assert_inc_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_inc != '0);

  assert_inc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_pend_q |=> $stable(active_inc));

  assert_inc_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_pend_q && staged_inc != '0) |=> active_inc == $past(staged_inc));
endmodule

// File: rtl/ptp_time_accum.sv
module ptp_time_accum
  import ptp_clk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [TIVL_W-1:0]  ival,
  input  logic [INC_W-1:0]   inc,
  input  logic               load_cmd,
  input  logic [TIME_W-1:0]  load_val,
  input  logic               add_cmd,
  input  logic               sub_cmd,
  input  logic [NUDGE_W-1:0] nudge_amt,
  output logic [TIME_W-1:0]  time_ns,
  output logic [FRAC_W-1:0]  time_frac
);
  logic [ACC_W-1:0] acc_q, acc_d, step;

  always_comb begin
    step = tick ? tick_step(inc, ival) : '0;
    if (load_cmd) acc_d = {load_val, {FRAC_W{1'b0}}};
    else          acc_d = acc_q + step + nudge_term(nudge_amt, add_cmd, sub_cmd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign time_ns   = acc_q[ACC_W-1:FRAC_W];
  assign time_frac = acc_q[FRAC_W-1:0];

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> (time_ns == $past(load_val) && time_frac == '0));

  assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_cmd && !(add_cmd ^ sub_cmd)) |=> ($stable(time_ns) && $stable(time_frac)));
endmodule

// File: rtl/ptp_frac_clock.sv
module ptp_frac_clock
  import ptp_clk_pkg::*;
#(
  parameter int unsigned REF_HZ = 600_000_000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] time_ns,
  output logic [31:0] time_frac,
  output logic        tick_pulse
);
  ctrl_t               ctrl;
  logic [TIME_W-1:0]   load_val;
  logic [NUDGE_W-1:0]  nudge_amt;
  logic [INC_W-1:0]    active_inc;
  logic                load_cmd, add_cmd, sub_cmd, tick;

  ptp_reg_file #(.REF_HZ(REF_HZ)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_time(time_ns),
    .ctrl(ctrl), .load_val(load_val), .nudge_amt(nudge_amt),
    .active_inc(active_inc), .load_cmd(load_cmd), .add_cmd(add_cmd),
    .sub_cmd(sub_cmd)
  );

  ptp_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run_en(ctrl.run_en), .ival(ctrl.tick_ival),
    .tick(tick)
  );

  ptp_time_accum u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ival(ctrl.tick_ival),
    .inc(active_inc), .load_cmd(load_cmd), .load_val(load_val),
    .add_cmd(add_cmd), .sub_cmd(sub_cmd), .nudge_amt(nudge_amt),
    .time_ns(time_ns), .time_frac(time_frac)
  );

  assign tick_pulse = tick;
endmodule

// File: tb/ptp_frac_clock_test.sv
module ptp_frac_clock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_ns;
  logic [31:0] time_frac;
  logic        tick_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptp_frac_clock uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns),
    .time_frac(time_frac), .tick_pulse(tick_pulse)
  );

  // {addr, write data, expected readback}
  localparam logic [67:0] VEC [10] = '{
    {4'd0,  32'hFFFF_FFFF, 32'h00F1_F111},
    {4'd0,  32'h00A0_5110, 32'h00A0_5110},
    {4'd0,  32'h0000_0000, 32'h0000_0000},
    {4'd2,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {4'd3,  32'h0123_4567, 32'h0123_4567},
    {4'd4,  32'h0000_0007, 32'h0000_0007},
    {4'd5,  32'h8000_0000, 32'h8000_0000},
    {4'd6,  32'hFFFF_0003, 32'h0000_0003},
    {4'd7,  32'h1234_5678, 32'h1234_5678},
    {4'd15, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [95:0] full();
    return {time_ns, time_frac};
  endfunction

  task automatic apply_inc(input logic [15:0] ns, input logic [31:0] fr);
    wr(4'd6, {16'h0, ns});
    wr(4'd7, fr);
    wr(4'd1, 32'h0100_0000);
    @(negedge clk);
  endtask

  // K must be a whole number of tick periods
  task automatic measure(input string req, input int k, input logic [95:0] inc);
    logic [95:0] t0;
    t0 = full();
    repeat (k) @(negedge clk);
    check(req, full(), t0 + 96'(k) * inc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [95:0] t0, d;
    logic [95:0] nom, nud, inc15;
    nom   = 96'h1_AAAA_AAAA;
    nud   = 96'h5_4000_0000;
    inc15 = 96'h1_8000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 time", full(), 96'h0);
    rd(4'd0, r); check("R1 ctrl", 96'(r), 96'h0);
    rd(4'd6, r); check("R1 inc ns", 96'(r), 96'h1);
    rd(4'd7, r); check("R1 inc frac", 96'(r), 96'hAAAA_AAAA);
    rd(4'd8, r); check("R9 hi at reset", 96'(r), 96'h0);
    wr(4'd0, 32'h1);
    measure("R1 nominal rate", 600, nom);
    wr(4'd0, 32'h0);

    // R2 register table
    foreach (VEC[i]) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], r);
      check($sformatf("R2 word %0d", VEC[i][67:64]), 96'(r), 96'(VEC[i][31:0]));
    end
    rd(4'd1, r); check("R2 cmd reads zero", 96'(r), 96'h0);

    // R5 load clears fraction (fraction nonzero from nominal run)
    wr(4'd2, 32'h0); wr(4'd3, 32'd1000); wr(4'd1, 32'h1);
    check("R5 load", full(), {64'd1000, 32'h0});
    rd(4'd9, r); check("R9 lo", 96'(r), 96'd1000);

    // R3 disabled hold
    t0 = full();
    repeat (10) @(negedge clk);
    check("R3 hold when off", full(), t0);

    // R4 / R9 high word crossing
    wr(4'd2, 32'h5); wr(4'd3, 32'hFFFF_FFF0); wr(4'd1, 32'h1);
    apply_inc(16'd16, 32'h0);
    wr(4'd0, 32'h1);
    measure("R4 rate 16", 4, 96'h10_0000_0000);
    wr(4'd0, 32'h0);
    rd(4'd8, r); check("R9 hi", 96'(r), 96'(time_ns[63:32]));
    rd(4'd9, r); check("R9 lo2", 96'(r), 96'(time_ns[31:0]));
    check("R4 crossed", 96'(time_ns[63:32]), 96'h6);

    // R3 tick interval 3
    wr(4'd0, 32'h0030_0001);
    measure("R3 interval rate", 16, 96'h10_0000_0000);
    t0 = full();
    @(negedge clk);
    d = full() - t0;
    check("R3 tick grain", d, (d == 96'h40_0000_0000) ? 96'h40_0000_0000 : 96'h0);

    // R7 staged without apply
    wr(4'd0, 32'h1);
    wr(4'd6, 32'd3); wr(4'd7, 32'h0);
    measure("R7 staged no effect", 8, 96'h10_0000_0000);
    wr(4'd1, 32'h0100_0000);
    @(negedge clk);
    measure("R7 applied", 8, 96'h3_0000_0000);

    // R8 zero refused
    apply_inc(16'd0, 32'h0);
    rd(4'd6, r); check("R8 staged zero visible", 96'(r), 96'h0);
    measure("R8 zero ignored", 8, 96'h3_0000_0000);

    // R4 fractional increment
    apply_inc(16'd1, 32'h8000_0000);
    measure("R4 frac rate", 7, inc15);

    // R5 load wins over tick and nudge
    wr(4'd4, 32'd9); wr(4'd5, 32'h0);
    wr(4'd2, 32'h0); wr(4'd3, 32'd500);
    wr(4'd1, 32'h0001_0001);
    check("R5 load priority", full(), {64'd500, 32'h0});

    // R6 nudge combined with tick
    wr(4'd4, 32'd5); wr(4'd5, 32'h4000_0000);
    t0 = full();
    wr(4'd1, 32'h0001_0000);
    check("R6 nudge with tick", full(), t0 + inc15 + nud);

    // R6 nudges while stopped
    wr(4'd0, 32'h0);
    t0 = full();
    wr(4'd1, 32'h0001_0000);
    check("R6 add", full(), t0 + nud);
    wr(4'd1, 32'h0000_0100);
    check("R6 sub", full(), t0);
    wr(4'd1, 32'h0001_0100);
    check("R6 cancel", full(), t0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule